// File: doc/BRIEF.md
# Interline CCD Readout Timing Generator

This block produces the logic-level phase enables that an interline CCD needs to read one frame. The enables cover the two vertical phases, the third-level flag on the second vertical phase, the two horizontal phases, the right-half barrier phases, the reset gate, the fast line dump gate and the substrate shutter. External drivers turn them into analog levels. A frame starts with an optional shutter pulse and an integration wait. Next comes the photodiode-to-vertical-register transfer, and then one line cycle per line read. Each line cycle is a vertical row shift, a hold gap, and a burst of horizontal pixel clocks.

All durations are counted in system-clock cycles and are set by parameters. A start pulse latches the frame's configuration. That configuration selects single or dual output, vertical binning by two, how many leading line reads are dumped through the fast dump gate, whether the shutter is used, and how long the wait after the shutter is. The configuration stays frozen until the frame ends. The interlocks are built into the sequence. The horizontal phases are parked while a row moves. Pixel clocking waits for the hold gap. The shutter, the vertical phases and the dump gate stay quiet while pixels shift.

Top module: `ccdtg_top`

## Requirements
- R1: After reset, and whenever no frame runs, busy=0, h1=1, h2=0, v1=0, v2=1, v2_hi=0, rg=0, fd=0 and sub=0.
- R2: A start pulse in idle raises busy on the next cycle. The frame performs LINES line reads, each marked by one v1 pulse, or LINES/2 reads with binning. busy then falls.
- R3: Whenever v1 is high, h1 is high and h2 is low.
- R4: After v1 falls on a line that is read out, exactly T_HD cycles pass with v1=0 and rg=0 before the first rg pulse.
- R5: Each v1 pulse lasts T_VCCD cycles, or 3*T_VCCD cycles when binning by two is latched.
- R6: A read line has PIX_SINGLE reset pulses in single mode and PIX_DUAL in dual mode, spaced PIX_PER cycles apart. rg is high in the first cycle of each pixel. h1 is high for the first PIX_PER/2 cycles of the pixel and low for the rest, and h2 is its complement.
- R7: In single mode h1br equals h2 and h2br equals h1. In dual mode h1br equals h1 and h2br equals h2.
- R8: Line reads 0 to dump_lines-1 hold fd high for the whole v1 pulse and get no pixel clocking. All later reads keep fd low.
- R9: With shutter enabled, sub is high for T_S cycles from the first busy cycle. Then exactly shut_delay cycles pass before v2_hi rises. With the shutter disabled, sub stays low.
- R10: v2_hi is high for T_PD cycles once per frame, before the first v1 pulse.
- R11: Configuration inputs and start are sampled only in idle. A change of mode, binning or dump count during a frame has no effect on that frame. A start pulse during a frame does not start a new one.
- R12: While rg is high or h1 is low, v1, fd and sub are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (sampled in idle only) |
| dual_mode | input | 1 | 1 = dual output, 0 = single output |
| bin2 | input | 1 | 1 = vertical binning by two |
| dump_lines | input | LINE_W | Number of leading line reads to discard |
| shut_en | input | 1 | Use the electronic shutter pulse |
| shut_delay | input | SD_W | Cycles from shutter end to photodiode transfer |
| v1 | output | 1 | Vertical phase 1 enable |
| v2 | output | 1 | Vertical phase 2 enable |
| v2_hi | output | 1 | Third-level flag on vertical phase 2 (photodiode transfer) |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| h1br | output | 1 | Right-half barrier phase 1 |
| h2br | output | 1 | Right-half barrier phase 2 |
| rg | output | 1 | Reset gate pulse, one per pixel |
| fd | output | 1 | Fast line dump gate |
| sub | output | 1 | Substrate shutter pulse |
| busy | output | 1 | Frame in progress |

## Verification
The hardest case to reach from the ports is a configuration change in the middle of a frame. The frozen copy can only be seen indirectly, through pixel counts, pulse widths and barrier mapping on later lines. The stimulus flips the mode, binning and dump inputs and pulses start while the first line is being clocked. It then checks that every line of the frame still matches the configuration given at the start, and that no second frame follows. Dumped lines are also hard to observe, because their effect is missing pixel clocks rather than new activity. The bench therefore counts reset pulses per v1 pulse, and measures the hold gap only on lines that are actually read.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXPOSE,
        ST_PDX,
        ST_VSHIFT,
        ST_HOLD,
        ST_HCLK,
        ST_DONE
    } tg_state_e;

    typedef struct packed {
        logic dual;
        logic bin2;
        logic shut_en;
    } tg_mode_t;

    typedef struct packed {
        logic v1;
        logic v2;
        logic v2_hi;
        logic fd;
        logic sub;
    } vert_ctl_t;

    typedef struct packed {
        logic h1;
        logic h2;
        logic rg;
    } horz_ctl_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ccdtg_hclk.sv
module ccdtg_hclk
    import ccdtg_pkg::*;
#(
    parameter int PIX_SINGLE = 1644,
    parameter int PIX_DUAL   = 824,
    parameter int PIX_PER    = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      dual,
    output horz_ctl_t hz,
    output logic      last
);
    localparam int PIX_W = $clog2(PIX_SINGLE + 1);
    localparam int PH_W  = (PIX_PER > 2) ? $clog2(PIX_PER) : 1;
    localparam int HALF  = PIX_PER / 2;

    logic [PH_W-1:0]  phase;
    logic [PIX_W-1:0] pix;
    logic [PIX_W-1:0] pix_last;
    logic             ph_end;

    assign ph_end   = (phase == PH_W'(PIX_PER - 1));
    assign pix_last = dual ? PIX_W'(PIX_DUAL - 1) : PIX_W'(PIX_SINGLE - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
            pix   <= '0;
        end else if (ph_end) begin
            phase <= '0;
            pix   <= pix + PIX_W'(1);
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

    // Parked state (h1 high, h2 low) whenever not running.
    always_comb begin
        hz.h1 = !run || (phase < PH_W'(HALF));
        hz.h2 = !hz.h1;
        hz.rg = run && (phase == '0);
    end

    assign last = run && ph_end && (pix == pix_last);

endmodule

// File: rtl/ccdtg_seq.sv
module ccdtg_seq
    import ccdtg_pkg::*;
#(
    parameter int LINES  = 1214,
    parameter int LINE_W = 11,
    parameter int SD_W   = 10,
    parameter int T_VCCD = 60,
    parameter int T_HD   = 60,
    parameter int T_PD   = 60,
    parameter int T_S    = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dual_i,
    input  logic              bin2_i,
    input  logic              shut_en_i,
    input  logic [LINE_W-1:0] dump_i,
    input  logic [SD_W-1:0]   sdel_i,
    input  logic              hlast_i,
    output logic              hrun_o,
    output logic              dual_o,
    output vert_ctl_t         vert_o,
    output logic              busy_o
);
    localparam int MAXT  = max2(max2(3 * T_VCCD, T_HD), max2(T_PD, T_S + (1 << SD_W)));
    localparam int CNT_W = $clog2(MAXT + 1);

    tg_state_e         st;
    tg_mode_t          mode_q;
    logic [LINE_W-1:0] dump_q;
    logic [SD_W-1:0]   sdel_q;
    logic [LINE_W-1:0] li;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  vlast;
    logic [CNT_W-1:0]  xlast;
    logic [LINE_W-1:0] li_last;
    logic              dumping;
    logic              final_line;

    assign vlast      = mode_q.bin2 ? CNT_W'(3 * T_VCCD - 1) : CNT_W'(T_VCCD - 1);
    assign xlast      = CNT_W'(T_S) + CNT_W'(sdel_q) - CNT_W'(1);
    assign li_last    = mode_q.bin2 ? LINE_W'(LINES / 2 - 1) : LINE_W'(LINES - 1);
    assign dumping    = (li < dump_q);
    assign final_line = (li == li_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            li     <= '0;
            mode_q <= '0;
            dump_q <= '0;
            sdel_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    li  <= '0;
                    if (start) begin
                        mode_q <= '{dual: dual_i, bin2: bin2_i, shut_en: shut_en_i};
                        dump_q <= dump_i;
                        sdel_q <= sdel_i;
                        st     <= shut_en_i ? ST_EXPOSE : ST_PDX;
                    end
                end
                ST_EXPOSE: begin
                    if (cnt == xlast) begin
                        cnt <= '0;
                        st  <= ST_PDX;
                    end else cnt <= cnt + CNT_W'(1);
                end
                ST_PDX: begin
                    if (cnt == CNT_W'(T_PD - 1)) begin
                        cnt <= '0;
                        st  <= ST_VSHIFT;
                    end else cnt <= cnt + CNT_W'(1);
                end
                ST_VSHIFT: begin
                    if (cnt == vlast) begin
                        cnt <= '0;
                        st  <= ST_HOLD;
                    end else cnt <= cnt + CNT_W'(1);
                end
                ST_HOLD: begin
                    if (cnt == CNT_W'(T_HD - 1)) begin
                        cnt <= '0;
                        if (!dumping) st <= ST_HCLK;
                        else if (final_line) st <= ST_DONE;
                        else begin
                            st <= ST_VSHIFT;
                            li <= li + LINE_W'(1);
                        end
                    end else cnt <= cnt + CNT_W'(1);
                end
                ST_HCLK: begin
                    if (hlast_i) begin
                        if (final_line) st <= ST_DONE;
                        else begin
                            st <= ST_VSHIFT;
                            li <= li + LINE_W'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        vert_o.v1    = (st == ST_VSHIFT);
        vert_o.v2    = (st != ST_VSHIFT);
        vert_o.v2_hi = (st == ST_PDX);
        vert_o.fd    = (st == ST_VSHIFT) && dumping;
        vert_o.sub   = (st == ST_EXPOSE) && (cnt < CNT_W'(T_S));
    end

    assign hrun_o = (st == ST_HCLK);
    assign dual_o = mode_q.dual;
    assign busy_o = (st != ST_IDLE);

    // R11: latched configuration never moves outside idle
    p_mode_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(mode_q) && $stable(dump_q));

    // R2: a frame always leaves through the done state
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE) |=> (st == ST_IDLE));

endmodule

// File: rtl/ccdtg_top.sv
module ccdtg_top
    import ccdtg_pkg::*;
#(
    parameter int LINES      = 1214,
    parameter int LINE_W     = 11,
    parameter int SD_W       = 10,
    parameter int PIX_SINGLE = 1644,
    parameter int PIX_DUAL   = 824,
    parameter int PIX_PER    = 4,
    parameter int T_VCCD     = 60,
    parameter int T_HD       = 60,
    parameter int T_PD       = 60,
    parameter int T_S        = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dual_mode,
    input  logic              bin2,
    input  logic [LINE_W-1:0] dump_lines,
    input  logic              shut_en,
    input  logic [SD_W-1:0]   shut_delay,
    output logic              v1,
    output logic              v2,
    output logic              v2_hi,
    output logic              h1,
    output logic              h2,
    output logic              h1br,
    output logic              h2br,
    output logic              rg,
    output logic              fd,
    output logic              sub,
    output logic              busy
);
    vert_ctl_t vc;
    horz_ctl_t hz;
    logic      hrun;
    logic      hlast;
    logic      dual_q;

    ccdtg_seq #(
        .LINES(LINES), .LINE_W(LINE_W), .SD_W(SD_W),
        .T_VCCD(T_VCCD), .T_HD(T_HD), .T_PD(T_PD), .T_S(T_S)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .dual_i(dual_mode), .bin2_i(bin2), .shut_en_i(shut_en),
        .dump_i(dump_lines), .sdel_i(shut_delay),
        .hlast_i(hlast), .hrun_o(hrun), .dual_o(dual_q),
        .vert_o(vc), .busy_o(busy)
    );

    ccdtg_hclk #(
        .PIX_SINGLE(PIX_SINGLE), .PIX_DUAL(PIX_DUAL), .PIX_PER(PIX_PER)
    ) u_hclk (
        .clk(clk), .rst(rst), .run(hrun), .dual(dual_q),
        .hz(hz), .last(hlast)
    );

    assign v1    = vc.v1;
    assign v2    = vc.v2;
    assign v2_hi = vc.v2_hi;
    assign fd    = vc.fd;
    assign sub   = vc.sub;
    assign h1    = hz.h1;
    assign h2    = hz.h2;
    assign rg    = hz.rg;

    // Right-half barrier phases follow the main phases in dual mode and are
    // swapped in single mode, so the right half shifts toward the left output.
    assign h1br = dual_q ? hz.h1 : hz.h2;
    assign h2br = dual_q ? hz.h2 : hz.h1;

    // R3: horizontal register parked during a row move
    p_hpark_r3: assert property (@(posedge clk) disable iff (rst)
        v1 |-> (h1 && !h2));

    // R12: no vertical, dump or shutter activity during pixel clocking
    p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (rg || !h1) |-> (!v1 && !fd && !sub));

    // R8: dump gate only inside a row move
    p_fd_in_shift_r8: assert property (@(posedge clk) disable iff (rst)
        fd |-> v1);

    // R4: hold gap begins when the row move ends
    p_hold_gap_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(v1) |-> (!rg && h1));

endmodule

// File: tb/ccdtg_top_tb.sv
module ccdtg_top_tb;
    localparam int LINES      = 6;
    localparam int LINE_W     = 4;
    localparam int SD_W       = 4;
    localparam int PIX_SINGLE = 10;
    localparam int PIX_DUAL   = 5;
    localparam int PIX_PER    = 4;
    localparam int HALF       = PIX_PER / 2;
    localparam int T_VCCD     = 3;
    localparam int T_HD       = 2;
    localparam int T_PD       = 4;
    localparam int T_S        = 3;

    logic clk = 0;
    logic rst = 1;
    logic start = 0, dual_mode = 0, bin2 = 0, shut_en = 0;
    logic [LINE_W-1:0] dump_lines = '0;
    logic [SD_W-1:0]   shut_delay = '0;
    logic v1, v2, v2_hi, h1, h2, h1br, h2br, rg, fd, sub, busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ccdtg_top #(
        .LINES(LINES), .LINE_W(LINE_W), .SD_W(SD_W),
        .PIX_SINGLE(PIX_SINGLE), .PIX_DUAL(PIX_DUAL), .PIX_PER(PIX_PER),
        .T_VCCD(T_VCCD), .T_HD(T_HD), .T_PD(T_PD), .T_S(T_S)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .dual_mode(dual_mode), .bin2(bin2),
        .dump_lines(dump_lines), .shut_en(shut_en), .shut_delay(shut_delay),
        .v1(v1), .v2(v2), .v2_hi(v2_hi), .h1(h1), .h2(h2), .h1br(h1br), .h2br(h2br),
        .rg(rg), .fd(fd), .sub(sub), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check(busy === 1'b0, {tag, " R1 busy"}, int'(busy), 0);
        check({h1, h2, v1, v2, v2_hi, rg, fd, sub} === 8'b1001_0000,
              {tag, " R1 idle levels"}, int'({h1, h2, v1, v2, v2_hi, rg, fd, sub}), 8'b1001_0000);
    endtask

    // Runs one frame, monitors every cycle, and checks against the requirements.
    task automatic run_frame(input bit dl, input bit bn, input int dmp,
                             input bit se, input int sd, input bit mid);
        int vlen[16], fdc[16], npx[16], gap[16];
        int nvs, n, ph, gcnt, sublen, subw, subph, v2hlen, v2h_before;
        int park_bad, shape_bad, space_bad, br_bad, quiet_bad;
        bit gapon, pv1, exp_h1;
        int nl, vl, np;
        nl = bn ? LINES / 2 : LINES;
        vl = bn ? 3 * T_VCCD : T_VCCD;
        np = dl ? PIX_DUAL : PIX_SINGLE;
        for (int i = 0; i < 16; i++) begin
            vlen[i] = 0; fdc[i] = 0; npx[i] = 0; gap[i] = -1;
        end
        nvs = 0; n = 0; ph = PIX_PER; gcnt = 0; sublen = 0; subw = 0; subph = 0;
        v2hlen = 0; v2h_before = 1; park_bad = 0; shape_bad = 0; space_bad = 0;
        br_bad = 0; quiet_bad = 0; gapon = 0; pv1 = 0;

        @(negedge clk);
        dual_mode = dl; bin2 = bn; dump_lines = LINE_W'(dmp);
        shut_en = se; shut_delay = SD_W'(sd); start = 1;
        @(negedge clk);
        start = 0;
        check(busy === 1'b1, "R2 busy after start", int'(busy), 1);

        while (busy === 1'b1 && n < 5000) begin
            if (v1) begin
                if (!pv1) nvs++;
                vlen[nvs-1]++;
                if (fd) fdc[nvs-1]++;
                if (h1 !== 1'b1 || h2 !== 1'b0) park_bad++;
                gapon = 0;
            end
            if (v2_hi) begin
                v2hlen++;
                if (nvs != 0) v2h_before = 0;
            end
            if (!v1 && pv1) begin
                gapon = 1;
                gcnt = 0;
            end
            if (rg) begin
                if (ph < PIX_PER - 1) space_bad++;
                ph = 0;
                if (nvs > 0) npx[nvs-1]++;
                if (gapon) begin
                    gap[nvs-1] = gcnt;
                    gapon = 0;
                end
            end else begin
                if (ph < PIX_PER) ph++;
                if (gapon) gcnt++;
            end
            exp_h1 = (ph < PIX_PER) ? (ph < HALF) : 1'b1;
            if (!v1 && (h1 !== exp_h1 || h2 !== !exp_h1)) shape_bad++;
            if (dl ? (h1br !== h1 || h2br !== h2) : (h1br !== h2 || h2br !== h1)) br_bad++;
            if ((rg || !h1) && (v1 || fd || sub)) quiet_bad++;
            if (sub) begin
                sublen++;
                if (subph == 0) subph = 1;
            end else if (subph == 1) subph = 2;
            if (subph == 2 && !v2_hi && v2hlen == 0) subw++;
            pv1 = v1;
            n++;
            @(negedge clk);
            if (mid && n == 25) begin
                dual_mode = !dl; bin2 = !bn; dump_lines = '0; start = 1;
            end
            if (mid && n == 26) start = 0;
        end

        check(n < 5000, "R2 watchdog: frame ended", n, 5000);
        check(nvs == nl, "R2/R5 line reads", nvs, nl);
        check(v2hlen == T_PD, "R10 v2_hi width", v2hlen, T_PD);
        check(v2h_before == 1, "R10 transfer before rows", v2h_before, 1);
        for (int i = 0; i < nl; i++) begin
            check(vlen[i] == vl, $sformatf("R5 v1 width line %0d", i), vlen[i], vl);
            if (i < dmp) begin
                check(fdc[i] == vl, $sformatf("R8 fd held line %0d", i), fdc[i], vl);
                check(npx[i] == 0, $sformatf("R8 no pixels line %0d", i), npx[i], 0);
            end else begin
                check(fdc[i] == 0, $sformatf("R8 fd low line %0d", i), fdc[i], 0);
                check(npx[i] == np, $sformatf("R6 pixel count line %0d", i), npx[i], np);
                check(gap[i] == T_HD, $sformatf("R4 hold gap line %0d", i), gap[i], T_HD);
            end
        end
        check(park_bad == 0, "R3 parked during v1", park_bad, 0);
        check(shape_bad == 0, "R6 h1/h2 waveform", shape_bad, 0);
        check(space_bad == 0, "R6 rg spacing", space_bad, 0);
        check(br_bad == 0, "R7 barrier mapping", br_bad, 0);
        check(quiet_bad == 0, "R12 quiet during pixels", quiet_bad, 0);
        if (se) begin
            check(sublen == T_S, "R9 sub width", sublen, T_S);
            check(subw == sd, "R9 shutter to transfer", subw, sd);
        end else begin
            check(sublen == 0, "R9 sub unused", sublen, 0);
        end
        check_idle("end of frame");
        if (mid) begin
            repeat (20) @(negedge clk);
            check(busy === 1'b0, "R11 no second frame", int'(busy), 0);
        end
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (3) @(negedge clk);
        check_idle("reset");
        rst = 0;
        repeat (2) @(negedge clk);
        check_idle("after reset");
    endtask

    task automatic t_single;   run_frame(0, 0, 0, 0, 0, 0); endtask
    task automatic t_dual;     run_frame(1, 0, 0, 0, 0, 0); endtask
    task automatic t_bin;      run_frame(0, 1, 0, 0, 0, 0); endtask
    task automatic t_dump;     run_frame(1, 0, 2, 0, 0, 0); endtask
    task automatic t_dump_bin; run_frame(0, 1, 1, 0, 0, 0); endtask
    task automatic t_dump_all; run_frame(0, 0, LINES, 0, 0, 0); endtask
    task automatic t_shutter;  run_frame(0, 0, 0, 1, 5, 0); endtask
    task automatic t_shut0;    run_frame(1, 1, 0, 1, 0, 0); endtask
    task automatic t_midchange;run_frame(0, 0, 1, 0, 0, 1); endtask

    initial begin
        t_reset();
        t_single();
        t_dual();
        t_bin();
        t_dump();
        t_dump_bin();
        t_dump_all();
        t_shutter();
        t_shut0();
        t_midchange();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule